// File: doc/BRIEF.md
# Jitter-Clocked Counter Entropy Sampler

This block turns a noisy, jittery pulse train into random digits or random bits by timing it against the system clock. The pulse input comes from an analog noise source or a relaxation oscillator outside the chip. It is asynchronous, so it first passes through a two-stage synchronizer and a rising-edge detector. Only the resulting one-cycle step pulse affects any state.

A build-time parameter picks one of two harvesting schemes. In counter mode, every noise step advances a small, fully synchronous counter. The counter wraps either at its natural binary limit or, when the decade option is set, at ten. A slow, regular sample tick from the surrounding logic latches the count. The latched count is presented as one hexadecimal or decimal digit, with a one-cycle valid strobe. In capture mode, a fast toggle flips on every system clock. Each noise step captures the toggle's current state as one random bit. The captured bits are also packed into a byte, which is flagged once every eight captures.

The rate of the noise input should be far below the clock rate, for example a hundred hertz against hundreds of megahertz. The jitter of each noise edge then spans many clock periods, and this jitter is what makes the captured phase, or the count between ticks, unpredictable.

Top module: `jitter_entropy_sampler`

## Requirements
- R1: While rst_n is low, and on the first sample after it rises, every valid output is 0, the digit, bit and byte outputs are 0, and the internal counters restart from 0.
- R2: Each 0-to-1 transition of noise_in produces exactly one step, provided the input stays high for at least one clock sample and low for at least one clock sample. A high level held for many cycles counts as one step only.
- R3: In counter mode with the decade option off, a 4-bit counter advances by one on each step and wraps from 15 to 0. The digit therefore equals the number of steps modulo 16.
- R4: In counter mode with the decade option on, the counter wraps from 9 to 0. The digit therefore equals the number of steps modulo 10.
- R5: A high sample_tick raises digit_valid for exactly the following cycle, and digit_out then shows the counter value as it stood at the tick. Reading the counter does not clear it, and digit_out holds its value between ticks.
- R6: When a tick and a step fall in the same cycle, the latched digit excludes that step, and the step is still counted for the next tick.
- R7: In capture mode, the fast toggle is 0 on the first clock edge after reset release and flips on every later edge. A step sampled on the m-th edge after release yields bit_out = (m-1) mod 2, with bit_valid high for that one cycle.
- R8: In capture mode, each bit enters byte_out at bit 0 and older bits move toward bit 7. byte_valid rises together with the eighth bit_valid of each group of eight, and byte_out then holds those eight bits.
- R9: The outputs of the mode that is not selected (digit_out and digit_valid, or bit_out, bit_valid, byte_out and byte_valid) stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it also drives the fast toggle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| noise_in | input | 1 | Asynchronous jittery pulse input from the noise source |
| sample_tick | input | 1 | Slow regular read strobe, synchronous to clk (counter mode) |
| digit_out | output | DIGIT_W | Latched counter value (counter mode) |
| digit_valid | output | 1 | One-cycle strobe for a new digit |
| bit_out | output | 1 | Last captured toggle state (capture mode) |
| bit_valid | output | 1 | One-cycle strobe for a new bit |
| byte_out | output | BYTE_W | Last completed group of captured bits |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |

## Verification
The assertions assume two things about the inputs: sample_tick is synchronous to clk, and rst_n is released on a clock boundary. Only then do the cycle relations between a tick, a step and the strobes that follow hold exactly. They also assume that noise_in holds each level for at least one full clock period, so that the synchronizer sees every edge. The stimulus changes noise_in and sample_tick only on falling clock edges, and it keeps each pulse high and low for one or more whole cycles. The gaps between pulses vary in length, so the captured toggle phase takes both values. One tick is placed in the exact cycle in which a step lands.

// File: rtl/entropy_pkg.sv
package entropy_pkg;

  typedef enum logic {
    MODE_COUNT   = 1'b0,
    MODE_CAPTURE = 1'b1
  } sampler_mode_e;

  // number of distinct counter states for a given width / decade choice
  function automatic int unsigned wrap_limit(int unsigned width, bit decade);
    return decade ? 32'd10 : (32'd1 << width);
  endfunction

endpackage

// File: rtl/noise_sync_edge.sv
module noise_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/pulse_digit_counter.sv
module pulse_digit_counter
  import entropy_pkg::*;
#(
  parameter int unsigned DIGIT_W = 4,
  parameter bit          DECADE  = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic               tick_i,
  output logic [DIGIT_W-1:0] digit_o,
  output logic               valid_o
);

  localparam int unsigned        LIMIT = wrap_limit(DIGIT_W, DECADE);
  localparam logic [DIGIT_W-1:0] TOP   = DIGIT_W'(LIMIT - 1);

  logic [DIGIT_W-1:0] cnt_q, cnt_d;
  logic [DIGIT_W-1:0] digit_q, digit_d;
  logic               vld_q, vld_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step_i) begin
      if (cnt_q == TOP) cnt_d = '0;
      else              cnt_d = cnt_q + DIGIT_W'(1);
    end
    digit_d = tick_i ? cnt_q : digit_q;
    vld_d   = tick_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      digit_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
      if (tick_i) digit_q <= digit_d;
    end
  end

  assign digit_o = digit_q;
  assign valid_o = vld_q;

  // R3 R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(cnt_q));

  // R5
  tick_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> valid_o);

  // R5
  digit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !valid_o && $stable(digit_o));

endmodule

// File: rtl/phase_bit_capture.sv
module phase_bit_capture #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic              bit_o,
  output logic              bit_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o
);

  localparam int unsigned     CW   = $clog2(BYTE_W);
  localparam logic [CW-1:0]   LAST = CW'(BYTE_W - 1);

  logic              tog_q, tog_d;
  logic              bit_q, bit_d, bvld_q, bvld_d;
  logic [BYTE_W-1:0] sh_q, sh_d, byte_q, byte_d;
  logic [CW-1:0]     n_q, n_d;
  logic              byvld_q, byvld_d;
  logic              last_step;

  always_comb begin
    tog_d     = ~tog_q;
    last_step = step_i && (n_q == LAST);
    sh_d      = {sh_q[BYTE_W-2:0], tog_q};
    n_d       = last_step ? '0 : n_q + CW'(1);
    bit_d     = tog_q;
    bvld_d    = step_i;
    byte_d    = sh_d;
    byvld_d   = last_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q   <= 1'b0;
      bit_q   <= 1'b0;
      bvld_q  <= 1'b0;
      sh_q    <= '0;
      n_q     <= '0;
      byte_q  <= '0;
      byvld_q <= 1'b0;
    end else begin
      tog_q   <= tog_d;
      bvld_q  <= bvld_d;
      byvld_q <= byvld_d;
      if (step_i) begin
        bit_q <= bit_d;
        sh_q  <= sh_d;
        n_q   <= n_d;
      end
      if (last_step) byte_q <= byte_d;
    end
  end

  assign bit_o        = bit_q;
  assign bit_valid_o  = bvld_q;
  assign byte_o       = byte_q;
  assign byte_valid_o = byvld_q;

  // R7
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tog_q != $past(tog_q));

  // R7
  bit_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> bit_valid_o && (bit_o == $past(tog_q)));

  // R8
  byte_with_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> bit_valid_o && (byte_o[0] == bit_o));

endmodule

// File: rtl/jitter_entropy_sampler.sv
module jitter_entropy_sampler
  import entropy_pkg::*;
#(
  parameter sampler_mode_e MODE        = MODE_COUNT,
  parameter int unsigned   DIGIT_W     = 4,
  parameter bit            DECADE      = 1'b0,
  parameter int unsigned   BYTE_W      = 8,
  parameter int unsigned   SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               noise_in,
  input  logic               sample_tick,
  output logic [DIGIT_W-1:0] digit_out,
  output logic               digit_valid,
  output logic               bit_out,
  output logic               bit_valid,
  output logic [BYTE_W-1:0]  byte_out,
  output logic               byte_valid
);

  logic step;

  noise_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (noise_in),
    .rise_o  (step)
  );

  generate
    if (MODE == MODE_COUNT) begin : g_count
      pulse_digit_counter #(.DIGIT_W(DIGIT_W), .DECADE(DECADE)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step),
        .tick_i  (sample_tick),
        .digit_o (digit_out),
        .valid_o (digit_valid)
      );
      assign bit_out    = 1'b0;
      assign bit_valid  = 1'b0;
      assign byte_out   = '0;
      assign byte_valid = 1'b0;
    end else begin : g_capture
      logic unused_tick;
      assign unused_tick = sample_tick;
      phase_bit_capture #(.BYTE_W(BYTE_W)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step),
        .bit_o        (bit_out),
        .bit_valid_o  (bit_valid),
        .byte_o       (byte_out),
        .byte_valid_o (byte_valid)
      );
      assign digit_out   = '0;
      assign digit_valid = 1'b0;
    end
  endgenerate

  // R9
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == MODE_COUNT) ? (!bit_valid && !byte_valid) : !digit_valid);

endmodule

// File: tb/jitter_entropy_sampler_tb.sv
module jitter_entropy_sampler_tb;
  import entropy_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic noise_in = 1'b0;
  logic sample_tick = 1'b0;

  logic [3:0] hex_digit, dec_digit, cap_digit;
  logic       hex_dv, dec_dv, cap_dv;
  logic       hex_b, hex_bv, dec_b, dec_bv, cap_b, cap_bv;
  logic [7:0] hex_by, dec_by, cap_by;
  logic       hex_byv, dec_byv, cap_byv;

  always #2 clk = ~clk;

  jitter_entropy_sampler #(.MODE(MODE_COUNT), .DECADE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .noise_in(noise_in), .sample_tick(sample_tick),
    .digit_out(hex_digit), .digit_valid(hex_dv), .bit_out(hex_b), .bit_valid(hex_bv),
    .byte_out(hex_by), .byte_valid(hex_byv));

  jitter_entropy_sampler #(.MODE(MODE_COUNT), .DECADE(1'b1)) u_dec (
    .clk(clk), .rst_n(rst_n), .noise_in(noise_in), .sample_tick(sample_tick),
    .digit_out(dec_digit), .digit_valid(dec_dv), .bit_out(dec_b), .bit_valid(dec_bv),
    .byte_out(dec_by), .byte_valid(dec_byv));

  jitter_entropy_sampler #(.MODE(MODE_CAPTURE)) u_cap (
    .clk(clk), .rst_n(rst_n), .noise_in(noise_in), .sample_tick(sample_tick),
    .digit_out(cap_digit), .digit_valid(cap_dv), .bit_out(cap_b), .bit_valid(cap_bv),
    .byte_out(cap_by), .byte_valid(cap_byv));

  int total = 0;
  int bad = 0;
  int npulse = 0;
  int cyc = 0;
  int mbits = 0;
  logic [7:0] mshift = '0;
  bit idle_err = 1'b0;
  bit done = 1'b0;
  int exp_hex[$];
  int exp_dec[$];

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // cycle index since reset release
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  // driver tasks: push expected digits as the stimulus is applied
  task automatic noise_pulse(int hi, int lo);
    @(negedge clk) noise_in = 1'b1;
    repeat (hi) @(negedge clk);
    noise_in = 1'b0;
    repeat (lo) @(negedge clk);
    npulse++;
  endtask

  task automatic do_tick();
    @(negedge clk);
    @(negedge clk) sample_tick = 1'b1;
    exp_hex.push_back(npulse % 16);
    exp_dec.push_back(npulse % 10);
    @(negedge clk) sample_tick = 1'b0;
    @(negedge clk);
  endtask

  // R6: tick in the cycle the step reaches the counter
  task automatic tick_on_step();
    @(negedge clk) noise_in = 1'b1;
    @(negedge clk);
    @(negedge clk) sample_tick = 1'b1;
    exp_hex.push_back(npulse % 16);
    exp_dec.push_back(npulse % 10);
    @(negedge clk) begin sample_tick = 1'b0; noise_in = 1'b0; end
    npulse++;
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (hex_dv) begin
        if (exp_hex.size() == 0) chk(1'b0, "R5", "unexpected hex digit_valid", 1, 0);
        else begin
          int e;
          e = exp_hex.pop_front();
          chk(hex_digit == 4'(e), "R3 R5", "hex digit", int'(hex_digit), e);
        end
      end
      if (dec_dv) begin
        if (exp_dec.size() == 0) chk(1'b0, "R5", "unexpected decade digit_valid", 1, 0);
        else begin
          int e;
          e = exp_dec.pop_front();
          chk(dec_digit == 4'(e), "R4 R5", "decade digit", int'(dec_digit), e);
        end
      end
      if (cap_bv) begin
        bit eb;
        bit ebv;
        eb = 1'((cyc - 1) % 2);
        chk(cap_b == eb, "R7", "captured bit", int'(cap_b), int'(eb));
        mshift = {mshift[6:0], eb};
        mbits++;
        ebv = (mbits == 8);
        chk(cap_byv == ebv, "R8", "byte_valid", int'(cap_byv), int'(ebv));
        if (ebv) begin
          chk(cap_by == mshift, "R8", "byte value", int'(cap_by), int'(mshift));
          mbits = 0;
        end
      end else if (cap_byv) begin
        chk(1'b0, "R8", "byte_valid without bit_valid", 1, 0);
      end
      if (hex_bv || hex_byv || dec_bv || dec_byv || cap_dv ||
          hex_b || dec_b || hex_by != 0 || dec_by != 0 || cap_digit != 0)
        idle_err = 1'b1;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(hex_dv == 0 && hex_digit == 0, "R1", "hex outputs in reset", int'(hex_digit), 0);
    chk(cap_bv == 0 && cap_byv == 0 && cap_by == 0, "R1", "capture outputs in reset",
        int'(cap_by), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hex_dv == 0 && dec_dv == 0 && cap_bv == 0, "R1", "valids after release",
        int'(hex_dv) + int'(dec_dv) + int'(cap_bv), 0);
    do_tick();                                       // R1: count starts at 0
    for (int i = 0; i < 5; i++) noise_pulse(1 + (i % 2), 1 + (i % 3));
    do_tick();                                       // 5
    noise_pulse(9, 2);                               // R2: long high counts once
    do_tick();                                       // 6
    for (int i = 0; i < 17; i++) noise_pulse(1, 1 + (i % 4));
    do_tick();                                       // R3/R4 wrap: 23 -> 7 / 3
    do_tick();                                       // R5: no clear on read
    tick_on_step();                                  // R6: sees 23
    do_tick();                                       // 24
    for (int i = 0; i < 16; i++) noise_pulse(2, 1 + (i % 3));
    do_tick();                                       // 40
    repeat (4) @(negedge clk);
    chk(exp_hex.size() == 0 && exp_dec.size() == 0, "R5", "pending digits",
        exp_hex.size() + exp_dec.size(), 0);
    chk(mbits == 0, "R8", "bits left over after 40 captures", mbits, 0);
    chk(!idle_err, "R9", "unselected-mode outputs nonzero", int'(idle_err), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule